// File: doc/BRIEF.md
# Error Record Validate-and-Copy Engine

This engine moves one error record between an exchange buffer and a storage slot. Each memory is reached through a single synchronous RAM port that is one 64-bit word wide and returns read data one cycle after the request. The slot to use is chosen elsewhere and arrives on `slot_sel`. The exchange buffer and every slot are each `BUF_BYTES` long.

A store operation starts at a byte offset inside the exchange buffer. The engine first checks the offset. It then reads the record length field and the record identifier from fixed positions in the record header and validates both. Only after these checks pass does it copy the record into the slot, one word per cycle. Every slot byte past the record is set to 0xFF. A fetch operation reads the length field from the slot, applies the same length rule, and copies that many bytes into the exchange buffer at the offset. Exchange bytes outside that window keep their contents.

Each operation ends with a one-cycle `done` pulse and a status code. After a store, `rec_id` carries the identifier taken from the header.

Top module: `rec_xfer_engine`

## Requirements
- R1: An offset that is not a multiple of 8, or that is greater than `BUF_BYTES` minus 128, ends the operation with status FAIL (2'b11). No memory is written.
- R2: The record length is the unsigned little-endian 32-bit value at record bytes 20..23, which is the upper half of record word 2. A length below 128, or above `BUF_BYTES` minus the offset, gives FAIL. Nothing is written.
- R3: On a store, the little-endian 64-bit value at record bytes 96..103 (record word 12) appears on `rec_id`. A value of all zeros or all ones gives FAIL and leaves the slot untouched. `rec_id` changes only while an operation runs.
- R4: A successful store copies exactly `length` bytes, starting at exchange byte `offset`, into slot bytes 0 to `length`-1.
- R5: A successful store sets every slot byte from `length` to `BUF_BYTES`-1 to 0xFF. Every slot write is a full word with all byte enables set.
- R6: A fetch takes the length from the stored record, checks it as in R2, and copies `length` slot bytes to exchange byte `offset` onward. Byte enables protect every other exchange byte.
- R7: `busy` is high from the cycle after an accepted `start` until `done`, inclusive. `done` is high for exactly one cycle. Status is 2'b00 on success and 2'b11 on failure, and it holds until the next completion. Neither memory is accessed while idle or during the `done` cycle.
- R8: `done` is high in the cycle after the last memory access. Counting the accepting clock edge as edge 1, `done` follows edge `BUF_BYTES`/8+5 for a successful store and edge ceil(length/8)+4 for a successful fetch. An offset failure gives `done` after edge 2, a length failure after edge 3, and an identifier failure after edge 4.
- R9: A `start` seen while `busy` is ignored. The running operation completes exactly as it would have without it.
- R10: After reset, `busy`, `done`, `status` and `rec_id` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_read | input | 1 | 1 = fetch from slot, 0 = store into slot |
| rec_offset | input | 32 | Byte offset of the record in the exchange buffer |
| slot_sel | input | $clog2(NSLOTS) | Storage slot to use |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 2'b00 success, 2'b11 failure |
| rec_id | output | 64 | Identifier extracted by the last store |
| ex_en | output | 1 | Exchange RAM access enable |
| ex_we | output | 1 | Exchange RAM write |
| ex_addr | output | $clog2(BUF_BYTES/8) | Exchange RAM word address |
| ex_be | output | 8 | Exchange RAM byte enables |
| ex_wdata | output | 64 | Exchange RAM write data |
| ex_rdata | input | 64 | Exchange RAM read data, one cycle after request |
| sl_en | output | 1 | Slot RAM access enable |
| sl_we | output | 1 | Slot RAM write |
| sl_addr | output | $clog2(NSLOTS)+$clog2(BUF_BYTES/8) | Slot RAM word address, slot number in upper bits |
| sl_be | output | 8 | Slot RAM byte enables |
| sl_wdata | output | 64 | Slot RAM write data |
| sl_rdata | input | 64 | Slot RAM read data, one cycle after request |

## Verification
A wrong latched length or word count shows up as a `done` that arrives too early or too late against the R8 cycle figure. It also shows up at the word boundary where record bytes should stop and 0xFF padding, or protected exchange bytes, should begin. A header check that decides wrongly leaves the slot rewritten when it should be unchanged, or the reverse, so comparing the whole slot after every rejected store exposes it. A counter or pipeline-valid fault that misplaces the final word shows up in the last word of the copy. Failure latencies of two, three and four cycles show which check ended the operation.

// File: rtl/rec_xfer_engine.sv
module rec_xfer_engine #(
  parameter int BUF_BYTES = 4096,
  parameter int NSLOTS    = 16,
  parameter int MIN_REC   = 128
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  input  logic                                         op_read,
  input  logic [31:0]                                  rec_offset,
  input  logic [$clog2(NSLOTS)-1:0]                    slot_sel,
  output logic                                         busy,
  output logic                                         done,
  output logic [1:0]                                   status,
  output logic [63:0]                                  rec_id,
  output logic                                         ex_en,
  output logic                                         ex_we,
  output logic [$clog2(BUF_BYTES/8)-1:0]               ex_addr,
  output logic [7:0]                                   ex_be,
  output logic [63:0]                                  ex_wdata,
  input  logic [63:0]                                  ex_rdata,
  output logic                                         sl_en,
  output logic                                         sl_we,
  output logic [$clog2(NSLOTS)+$clog2(BUF_BYTES/8)-1:0] sl_addr,
  output logic [7:0]                                   sl_be,
  output logic [63:0]                                  sl_wdata,
  input  logic [63:0]                                  sl_rdata
);
  localparam int WORDS = BUF_BYTES / 8;
  localparam int AW    = $clog2(WORDS);
  localparam int SLW   = $clog2(NSLOTS);
  localparam int CW    = AW + 1;
  localparam logic [31:0] OFF_LIM = 32'(BUF_BYTES - MIN_REC);
  localparam logic [31:0] BUF_LEN = 32'(BUF_BYTES);
  localparam logic [31:0] MIN_LEN = 32'(MIN_REC);
  localparam logic [1:0]  ST_OK   = 2'b00;
  localparam logic [1:0]  ST_FAIL = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_LEN, S_ID, S_COPY, S_DRAIN, S_FIN} state_t;

  state_t          state;
  logic            rd_q;
  logic [31:0]     off_q;
  logic [SLW-1:0]  slot_q;
  logic [31:0]     len_q;
  logic [CW-1:0]   nw_q;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   k1;
  logic            pv;
  logic [1:0]      status_q;
  logic [63:0]     id_q;

  logic [63:0] src_rd;
  logic [31:0] len_f;
  logic [31:0] room;
  logic [31:0] nw_f;
  logic        off_bad, len_bad, id_bad;
  logic [CW-1:0] ndst;
  logic [AW-1:0] wo;
  logic [63:0] pad_data;
  logic [7:0]  lane_in;

  assign src_rd  = rd_q ? sl_rdata : ex_rdata;
  assign len_f   = src_rd[63:32];
  assign room    = BUF_LEN - off_q;
  assign nw_f    = (len_f + 32'd7) >> 3;
  assign off_bad = (off_q > OFF_LIM) || (off_q[2:0] != 3'd0);
  assign len_bad = (len_f < MIN_LEN) || (len_f > room);
  assign id_bad  = (src_rd == 64'd0) || (src_rd == {64{1'b1}});
  assign ndst    = rd_q ? nw_q : CW'(WORDS);
  assign wo      = off_q[AW+2:3];

  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign lane_in[b] = (32'({k1, 3'(b)}) < len_q);
    assign pad_data[8*b +: 8] = lane_in[b] ? src_rd[8*b +: 8] : 8'hFF;
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
  assign status = status_q;
  assign rec_id = id_q;

  logic          src_req;
  logic [AW-1:0] src_idx;

  always_comb begin
    src_req = 1'b0;
    src_idx = '0;
    case (state)
      S_CHK:  begin src_req = !off_bad;              src_idx = AW'(2);  end
      S_LEN:  begin src_req = !rd_q && !len_bad;     src_idx = AW'(12); end
      S_COPY: begin src_req = (cnt < nw_q);          src_idx = cnt[AW-1:0]; end
      default: ;
    endcase
  end

  always_comb begin
    ex_en    = 1'b0;
    ex_we    = 1'b0;
    ex_addr  = '0;
    ex_be    = 8'h00;
    ex_wdata = '0;
    sl_en    = 1'b0;
    sl_we    = 1'b0;
    sl_addr  = '0;
    sl_be    = 8'h00;
    sl_wdata = '0;
    if (src_req) begin
      if (rd_q) begin
        sl_en   = 1'b1;
        sl_addr = {slot_q, src_idx};
      end else begin
        ex_en   = 1'b1;
        ex_addr = wo + src_idx;
      end
    end
    if (pv) begin
      if (rd_q) begin
        ex_en    = 1'b1;
        ex_we    = 1'b1;
        ex_addr  = wo + k1[AW-1:0];
        ex_be    = lane_in;
        ex_wdata = pad_data;
      end else begin
        sl_en    = 1'b1;
        sl_we    = 1'b1;
        sl_addr  = {slot_q, k1[AW-1:0]};
        sl_be    = 8'hFF;
        sl_wdata = pad_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rd_q     <= 1'b0;
      off_q    <= '0;
      slot_q   <= '0;
      len_q    <= '0;
      nw_q     <= '0;
      cnt      <= '0;
      k1       <= '0;
      pv       <= 1'b0;
      status_q <= ST_OK;
      id_q     <= '0;
    end else begin
      pv <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          rd_q   <= op_read;
          off_q  <= rec_offset;
          slot_q <= slot_sel;
          state  <= S_CHK;
        end
        S_CHK: begin
          if (off_bad) begin
            status_q <= ST_FAIL;
            state    <= S_FIN;
          end else begin
            state <= S_LEN;
          end
        end
        S_LEN: begin
          len_q <= len_f;
          nw_q  <= nw_f[CW-1:0];
          cnt   <= '0;
          if (len_bad) begin
            status_q <= ST_FAIL;
            state    <= S_FIN;
          end else if (rd_q) begin
            state <= S_COPY;
          end else begin
            state <= S_ID;
          end
        end
        S_ID: begin
          id_q <= src_rd;
          if (id_bad) begin
            status_q <= ST_FAIL;
            state    <= S_FIN;
          end else begin
            state <= S_COPY;
          end
        end
        S_COPY: begin
          pv  <= 1'b1;
          k1  <= cnt;
          cnt <= cnt + 1'b1;
          if (cnt == ndst - 1'b1) state <= S_DRAIN;
        end
        S_DRAIN: begin
          status_q <= ST_OK;
          state    <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rec_xfer_engine_chk.sv
module rec_xfer_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status,
  input logic [63:0] rec_id,
  input logic        ex_en,
  input logic        ex_we,
  input logic        sl_en,
  input logic        sl_we,
  input logic [7:0]  sl_be
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R7
  quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy || done) |-> (!ex_en && !sl_en));
  // R7
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (status == 2'b00 || status == 2'b11));
  // R5
  slot_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n) sl_we |-> (sl_be == 8'hFF));
  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(rec_id));
  // R6
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ex_we && sl_we));
endmodule

bind rec_xfer_engine rec_xfer_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .rec_id(rec_id), .ex_en(ex_en), .ex_we(ex_we),
  .sl_en(sl_en), .sl_we(sl_we), .sl_be(sl_be)
);

// File: tb/sim_rec_xfer_engine.sv
`timescale 1ns/1ps
module sim_rec_xfer_engine;
  localparam int BUF   = 4096;
  localparam int NS    = 4;
  localparam int WORDS = BUF / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0, op_read = 1'b0;
  logic [31:0] rec_offset = '0;
  logic [1:0]  slot_sel = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [63:0] rec_id;
  logic        ex_en, ex_we, sl_en, sl_we;
  logic [8:0]  ex_addr;
  logic [10:0] sl_addr;
  logic [7:0]  ex_be, sl_be;
  logic [63:0] ex_wdata, sl_wdata;
  logic [63:0] ex_rdata = '0, sl_rdata = '0;

  rec_xfer_engine #(.BUF_BYTES(BUF), .NSLOTS(NS), .MIN_REC(128)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
    .rec_offset(rec_offset), .slot_sel(slot_sel), .busy(busy), .done(done),
    .status(status), .rec_id(rec_id), .ex_en(ex_en), .ex_we(ex_we),
    .ex_addr(ex_addr), .ex_be(ex_be), .ex_wdata(ex_wdata), .ex_rdata(ex_rdata),
    .sl_en(sl_en), .sl_we(sl_we), .sl_addr(sl_addr), .sl_be(sl_be),
    .sl_wdata(sl_wdata), .sl_rdata(sl_rdata)
  );

  logic [63:0] ex_mem [0:WORDS-1];
  logic [63:0] sl_mem [0:NS*WORDS-1];
  logic        ex_bd_we = 1'b0, sl_bd_we = 1'b0;
  logic [8:0]  ex_bd_a = '0;
  logic [10:0] sl_bd_a = '0;
  logic [63:0] ex_bd_d = '0, sl_bd_d = '0;

  always @(posedge clk) begin
    if (ex_bd_we) ex_mem[ex_bd_a] <= ex_bd_d;
    else if (ex_en) begin
      if (ex_we) begin
        for (int b = 0; b < 8; b++)
          if (ex_be[b]) ex_mem[ex_addr][8*b +: 8] <= ex_wdata[8*b +: 8];
      end else ex_rdata <= ex_mem[ex_addr];
    end
    if (sl_bd_we) sl_mem[sl_bd_a] <= sl_bd_d;
    else if (sl_en) begin
      if (sl_we) begin
        for (int b = 0; b < 8; b++)
          if (sl_be[b]) sl_mem[sl_addr][8*b +: 8] <= sl_wdata[8*b +: 8];
      end else sl_rdata <= sl_mem[sl_addr];
    end
  end

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'(a * 13 + seed * 7 + (a >> 8));
  endfunction

  function automatic logic [7:0] fld(input int a, input int seed, input int base,
                                     input int len, input logic [63:0] id, input bit put);
    int rel = a - base;
    if (put && rel >= 20 && rel < 24) return 8'(len >> (8 * (rel - 20)));
    if (put && rel >= 96 && rel < 104) return 8'(id >> (8 * (rel - 96)));
    return pat(a, seed);
  endfunction

  function automatic logic [7:0] ex_byte(input int a);
    return ex_mem[a >> 3][8*(a & 7) +: 8];
  endfunction

  function automatic logic [7:0] sl_byte(input int s, input int a);
    return sl_mem[s*WORDS + (a >> 3)][8*(a & 7) +: 8];
  endfunction

  task automatic fill_ex(input int seed, input int off, input int len, input logic [63:0] id, input bit put);
    for (int w = 0; w < WORDS; w++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[8*b +: 8] = fld(8*w + b, seed, off, len, id, put);
      @(negedge clk);
      ex_bd_we = 1'b1; ex_bd_a = 9'(w); ex_bd_d = d;
    end
    @(negedge clk);
    ex_bd_we = 1'b0;
  endtask

  task automatic fill_sl(input int s, input int seed, input int len, input bit put);
    for (int w = 0; w < WORDS; w++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[8*b +: 8] = fld(8*w + b, seed, 0, len, 64'h0, put);
      @(negedge clk);
      sl_bd_we = 1'b1; sl_bd_a = 11'(s*WORDS + w); sl_bd_d = d;
    end
    @(negedge clk);
    sl_bd_we = 1'b0;
  endtask

  task automatic run(input bit rd, input int off, input int s, input bit inj,
                     output int cyc, output logic [1:0] st);
    @(negedge clk);
    start = 1'b1; op_read = rd; rec_offset = 32'(off); slot_sel = 2'(s);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    while (!done && cyc < 3000) begin
      if (inj && cyc == 3) begin
        start = 1'b1; op_read = ~rd; rec_offset = 32'd0; slot_sel = 2'(s + 1);
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    st = status;
    if (cyc >= 3000) chk(1'b0, "R7 done never came", 64'(cyc), 64'd0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done lasts one cycle", {62'd0, done, busy}, 64'd0);
  endtask

  task automatic t_store(input string tag, input int off, input int len, input logic [63:0] id,
                         input int s, input bit exp_ok, input int exp_lat, input bit inj);
    int cyc; logic [1:0] st; int bad; logic [7:0] a8, e8;
    fill_ex(11, off, len, id, 1'b1);
    fill_sl(s, 29, 0, 1'b0);
    run(1'b0, off, s, inj, cyc, st);
    chk(st == (exp_ok ? 2'b00 : 2'b11), {tag, " store status"}, 64'(st), exp_ok ? 64'd0 : 64'd3);
    chk(cyc == exp_lat, "R8 store latency", 64'(cyc), 64'(exp_lat));
    if (exp_ok || (tag == "R3")) chk(rec_id == id, "R3 rec_id", rec_id, id);
    bad = 0; a8 = 0; e8 = 0;
    for (int i = 0; i < BUF; i++) begin
      logic [7:0] e = !exp_ok ? pat(i, 29) : (i < len ? ex_byte(off + i) : 8'hFF);
      if (sl_byte(s, i) !== e) begin
        if (bad == 0) begin a8 = sl_byte(s, i); e8 = e; end
        bad++;
      end
    end
    if (exp_ok) chk(bad == 0, "R4 R5 slot image", 64'(a8), 64'(e8));
    else        chk(bad == 0, {tag, " slot untouched"}, 64'(a8), 64'(e8));
  endtask

  task automatic t_fetch(input string tag, input int off, input int len, input int s,
                         input bit exp_ok, input int exp_lat);
    int cyc; logic [1:0] st; int bad; logic [7:0] a8, e8;
    fill_sl(s, 41, len, 1'b1);
    fill_ex(53, 0, 0, 64'h0, 1'b0);
    run(1'b1, off, s, 1'b0, cyc, st);
    chk(st == (exp_ok ? 2'b00 : 2'b11), {tag, " fetch status"}, 64'(st), exp_ok ? 64'd0 : 64'd3);
    chk(cyc == exp_lat, "R8 fetch latency", 64'(cyc), 64'(exp_lat));
    bad = 0; a8 = 0; e8 = 0;
    for (int a = 0; a < BUF; a++) begin
      logic [7:0] e = (exp_ok && a >= off && a < off + len) ? sl_byte(s, a - off) : pat(a, 53);
      if (ex_byte(a) !== e) begin
        if (bad == 0) begin a8 = ex_byte(a); e8 = e; end
        bad++;
      end
    end
    chk(bad == 0, {tag, " exchange image"}, 64'(a8), 64'(e8));
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && done == 1'b0, "R10 reset handshake", {62'd0, busy, done}, 64'd0);
    chk(status == 2'b00, "R10 reset status", 64'(status), 64'd0);
    chk(rec_id == 64'd0, "R10 reset rec_id", rec_id, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vecs, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_store("R4", 0,    128,  64'h1122_3344_5566_7788, 1, 1'b1, WORDS + 5, 1'b0);
    t_store("R4", 296,  1003, 64'h0000_0000_0000_0001, 2, 1'b1, WORDS + 5, 1'b0);
    t_store("R5", 3968, 128,  64'hFFFF_FFFF_FFFF_FFFE, 0, 1'b1, WORDS + 5, 1'b0);
    t_store("R2", 1024, 3072, 64'hDEAD_BEEF_0BAD_F00D, 3, 1'b1, WORDS + 5, 1'b0);
    t_store("R9", 296,  1003, 64'h0123_4567_89AB_CDEF, 1, 1'b1, WORDS + 5, 1'b1);
    t_store("R1", 3976, 128,  64'h55, 1, 1'b0, 2, 1'b0);
    t_store("R1", 12,   128,  64'h55, 1, 1'b0, 2, 1'b0);
    t_store("R2", 0,    127,  64'h55, 2, 1'b0, 3, 1'b0);
    t_store("R2", 1024, 3073, 64'h55, 2, 1'b0, 3, 1'b0);
    t_store("R3", 64,   256,  64'h0, 3, 1'b0, 4, 1'b0);
    t_store("R3", 64,   256,  64'hFFFF_FFFF_FFFF_FFFF, 3, 1'b0, 4, 1'b0);
    t_fetch("R6", 1040, 1003, 2, 1'b1, 126 + 4);
    t_fetch("R6", 3968, 128,  1, 1'b1, 16 + 4);
    t_fetch("R6", 0,    4096, 0, 1'b1, WORDS + 4);
    t_fetch("R2", 0,    100,  3, 1'b0, 3);
    t_fetch("R2", 2048, 3000, 3, 1'b0, 3);
    t_fetch("R1", 5,    256,  3, 1'b0, 2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule